// File: doc/BRIEF.md
# Global-Bus Snoop Controller with Abort and Retry

This block sits between a local processor port and a shared memory bus. It keeps a copy of the tag, valid and modified state for each line of a direct-mapped cache. Only address phases that other masters mark as global are looked up. If another master reads a line that is held modified, the block answers with an abort reply. It then wins the bus and writes the line back to memory, and the aborted master reads memory again on its retry. If another master writes a cached line, the line is invalidated.

The block also holds the local requester. A local miss issues a line read on the bus. When that read is aborted, the requester releases the bus, waits a fixed number of cycles and then asks for the bus again. A dirty line that a fill would replace is written back first. The local port is stalled for the cycle in which the snoop tags are checked, and for as long as a fill or a writeback is outstanding. Bus arbitration is a plain request/grant pair.

The address splits into a line offset, an index and a tag, from the least significant bit upward. Reply codes are 2'b00 for no reply, 2'b01 for success and 2'b11 for abort.

Top module: `snoop_retry_ctl`

## Requirements
- R1: A bus address phase with bus_global low causes no reply, no stall and no change of line state. A later global read of the same line still sees the line as modified.
- R2: A global read address phase in cycle T that hits a modified line drives snp_reply = 2'b11 in cycle T+1.
- R3: A global read that hits a clean line, or that misses, drives snp_reply = 2'b00, and a clean line stays valid.
- R4: After an abort the block raises m_req. Once granted, it drives BEATS consecutive cycles of m_valid=1 and m_write=1, with m_addr equal to the line base and m_beat counting 0 up to BEATS-1. It then drops m_req.
- R5: After that writeback the line stays valid and becomes clean. A local read hits it, and a later global read of it is not aborted.
- R6: A global write that hits a cached line invalidates it, so the next local read misses.
- R7: cpu_wait is high in the cycle after any global address phase from another master (the tag-check cycle).
- R8: A local miss requests the bus and issues one read address phase with m_valid=1, m_write=0, m_addr equal to the line base and m_global equal to cpu_global. If the reply is 2'b11, m_req stays low for exactly RETRY_GAP cycles before the read is requested again.
- R9: A reply of 2'b01 installs the line. A read miss installs it clean and a write miss installs it modified; local accesses to it then hit.
- R10: While a writeback is pending or in progress, every global address phase is answered with 2'b11, even one that misses.
- R11: A miss whose index holds a modified line of another tag first writes that line back (as in R4) and only then issues the read.
- R12: A local write that hits a line marks it modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Local access request |
| cpu_we | input | 1 | Local access is a write |
| cpu_global | input | 1 | Local access targets shared memory |
| cpu_addr | input | ADDR_W | Local byte address |
| cpu_wait | output | 1 | Local access must be held |
| cpu_hit | output | 1 | Accepted local access hit |
| bus_valid | input | 1 | Address phase of another master |
| bus_write | input | 1 | That phase is a write |
| bus_global | input | 1 | That phase targets shared memory |
| bus_addr | input | ADDR_W | That phase's address |
| snp_reply | output | 2 | Reply to the observed phase |
| m_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| m_valid | output | 1 | Own bus cycle valid |
| m_write | output | 1 | Own bus cycle is a write |
| m_global | output | 1 | Own cycle targets shared memory |
| m_addr | output | ADDR_W | Own cycle line address |
| m_beat | output | $clog2(BEATS) | Writeback beat index |
| bus_reply | input | 2 | Reply to own read |

## Verification
The bench builds the block with IDX_W=3, BEATS=4 and RETRY_GAP=3. With eight lines, two small addresses can share an index, and that is what drives the dirty-victim path. A gap of three cycles cannot be mistaken for a one-cycle back-off. Four beats show the writeback address holding steady while the beat index counts. The bench also sends a global snoop while a writeback still waits for its grant, which covers the blanket-abort rule.

// File: rtl/snoop_retry_ctl.sv
module snoop_retry_ctl #(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int IDX_W     = 4,
  parameter int BEATS     = 4,
  parameter int RETRY_GAP = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic                       cpu_global,
  input  logic [ADDR_W-1:0]          cpu_addr,
  output logic                       cpu_wait,
  output logic                       cpu_hit,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic                       bus_global,
  input  logic [ADDR_W-1:0]          bus_addr,
  output logic [1:0]                 snp_reply,
  output logic                       m_req,
  input  logic                       bus_gnt,
  output logic                       m_valid,
  output logic                       m_write,
  output logic                       m_global,
  output logic [ADDR_W-1:0]          m_addr,
  output logic [$clog2(BEATS)-1:0]   m_beat,
  input  logic [1:0]                 bus_reply
);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int GAP_W  = $clog2(RETRY_GAP + 1);
  localparam logic [1:0] REPLY_OK    = 2'b01;
  localparam logic [1:0] REPLY_ABORT = 2'b11;

  typedef enum logic [1:0] {WB_IDLE, WB_REQ, WB_XFER} wb_state_t;
  typedef enum logic [2:0] {RQ_IDLE, RQ_REQ, RQ_ADDR, RQ_RESP, RQ_GAP} rq_state_t;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, mod_q;

  wb_state_t        wb_state;
  logic [IDX_W-1:0] wb_idx;
  logic [TAG_W-1:0] wb_tag;
  logic [BEAT_W-1:0] wb_beat;

  rq_state_t        rq_state;
  logic [IDX_W-1:0] rq_idx;
  logic [TAG_W-1:0] rq_tag;
  logic             rq_we, rq_glob;
  logic [GAP_W-1:0] gap_cnt;

  logic             chk_q, chk_wr_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [TAG_W-1:0] chk_tag_q;

  logic wb_busy, snoop_start, chk_hit, chk_dirty, chk_abort, chk_start_wb, chk_inval;
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  logic c_match, accept, miss_go, victim_dirty, wb_last, fill_ok;

  assign wb_busy     = wb_state != WB_IDLE;
  assign snoop_start = bus_valid && bus_global && !m_valid;

  assign chk_hit      = valid_q[chk_idx_q] && tag_q[chk_idx_q] == chk_tag_q;
  assign chk_dirty    = chk_hit && mod_q[chk_idx_q];
  assign chk_abort    = chk_q && (wb_busy || (!chk_wr_q && chk_dirty));
  assign chk_start_wb = chk_q && !wb_busy && !chk_wr_q && chk_dirty;
  assign chk_inval    = chk_q && !wb_busy && chk_wr_q && chk_hit;
  assign snp_reply    = chk_abort ? REPLY_ABORT : 2'b00;

  assign c_idx        = cpu_addr[OFF_W +: IDX_W];
  assign c_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_match      = valid_q[c_idx] && tag_q[c_idx] == c_tag;
  assign cpu_wait     = chk_q || wb_busy || rq_state != RQ_IDLE;
  assign accept       = cpu_req && !cpu_wait;
  assign cpu_hit      = accept && c_match;
  assign miss_go      = accept && !c_match;
  assign victim_dirty = valid_q[c_idx] && mod_q[c_idx];

  assign wb_last = wb_state == WB_XFER && wb_beat == BEAT_W'(BEATS - 1);
  assign fill_ok = rq_state == RQ_RESP && bus_reply == REPLY_OK;

  assign m_req    = wb_busy || rq_state == RQ_REQ || rq_state == RQ_ADDR || rq_state == RQ_RESP;
  assign m_valid  = wb_state == WB_XFER || rq_state == RQ_ADDR;
  assign m_write  = wb_state == WB_XFER;
  assign m_global = (wb_state == WB_XFER) ? 1'b1 : rq_glob;
  assign m_addr   = (wb_state == WB_XFER) ? {wb_tag, wb_idx, {OFF_W{1'b0}}}
                                          : {rq_tag, rq_idx, {OFF_W{1'b0}}};
  assign m_beat   = (wb_state == WB_XFER) ? wb_beat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= 1'b0; chk_wr_q <= 1'b0; chk_idx_q <= '0; chk_tag_q <= '0;
    end else begin
      chk_q     <= snoop_start;
      chk_wr_q  <= bus_write;
      chk_idx_q <= bus_addr[OFF_W +: IDX_W];
      chk_tag_q <= bus_addr[ADDR_W-1 -: TAG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      mod_q   <= '0;
    end else begin
      if (chk_inval) begin
        valid_q[chk_idx_q] <= 1'b0;
        mod_q[chk_idx_q]   <= 1'b0;
      end
      if (cpu_hit && cpu_we) mod_q[c_idx] <= 1'b1;
      if (wb_last) mod_q[wb_idx] <= 1'b0;
      if (fill_ok) begin
        valid_q[rq_idx] <= 1'b1;
        mod_q[rq_idx]   <= rq_we;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) tag_q[rq_idx] <= rq_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_state <= WB_IDLE; wb_idx <= '0; wb_tag <= '0; wb_beat <= '0;
    end else begin
      case (wb_state)
        WB_IDLE: begin
          wb_beat <= '0;
          if (chk_start_wb) begin
            wb_state <= WB_REQ;
            wb_idx   <= chk_idx_q;
            wb_tag   <= chk_tag_q;
          end else if (miss_go && victim_dirty) begin
            wb_state <= WB_REQ;
            wb_idx   <= c_idx;
            wb_tag   <= tag_q[c_idx];
          end
        end
        WB_REQ:
          if (bus_gnt && rq_state != RQ_ADDR && rq_state != RQ_RESP) wb_state <= WB_XFER;
        WB_XFER:
          if (wb_last) wb_state <= WB_IDLE;
          else wb_beat <= wb_beat + 1'b1;
        default: wb_state <= WB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_state <= RQ_IDLE; rq_idx <= '0; rq_tag <= '0;
      rq_we <= 1'b0; rq_glob <= 1'b0; gap_cnt <= '0;
    end else begin
      case (rq_state)
        RQ_IDLE:
          if (miss_go) begin
            rq_state <= RQ_REQ;
            rq_idx   <= c_idx;
            rq_tag   <= c_tag;
            rq_we    <= cpu_we;
            rq_glob  <= cpu_global;
          end
        RQ_REQ:
          if (bus_gnt && !wb_busy) rq_state <= RQ_ADDR;
        RQ_ADDR: rq_state <= RQ_RESP;
        RQ_RESP:
          if (bus_reply == REPLY_OK) rq_state <= RQ_IDLE;
          else if (bus_reply == REPLY_ABORT) begin
            rq_state <= RQ_GAP;
            gap_cnt  <= GAP_W'(RETRY_GAP - 1);
          end
        RQ_GAP:
          if (gap_cnt == '0) rq_state <= RQ_REQ;
          else gap_cnt <= gap_cnt - 1'b1;
        default: rq_state <= RQ_IDLE;
      endcase
    end
  end

  AST_ABORT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_reply == REPLY_ABORT |-> $past(rst_n && bus_valid && bus_global)); // R1
  AST_WAIT_IN_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && bus_valid && bus_global && !m_valid) |-> cpu_wait); // R7
  AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_state == RQ_RESP && bus_reply == REPLY_ABORT) |=> !m_valid); // R8
  AST_WB_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write && $past(rst_n && m_valid && m_write)) |-> $stable(m_addr)); // R4
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_state == WB_XFER, rq_state == RQ_ADDR, rq_state == RQ_RESP})); // R4
endmodule

// File: tb/snoop_retry_ctl_bench.sv
module snoop_retry_ctl_bench;
  localparam int ADDR_W = 16, OFF_W = 4, IDX_W = 3, BEATS = 4, GAP = 3;
  localparam int BW = $clog2(BEATS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_global = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_wait, cpu_hit;
  logic bus_valid = 0, bus_write = 0, bus_global = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [1:0] snp_reply;
  logic m_req, bus_gnt = 0, m_valid, m_write, m_global;
  logic [ADDR_W-1:0] m_addr;
  logic [BW-1:0] m_beat;
  logic [1:0] bus_reply = 2'b00;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  snoop_retry_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .BEATS(BEATS),
                    .RETRY_GAP(GAP)) u_snoop_retry_ctl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_global, .cpu_addr, .cpu_wait, .cpu_hit,
    .bus_valid, .bus_write, .bus_global, .bus_addr, .snp_reply, .m_req, .bus_gnt,
    .m_valid, .m_write, .m_global, .m_addr, .m_beat, .bus_reply);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_access(input logic [ADDR_W-1:0] a, input bit we, input bit glob,
                            output bit hit);
    for (int i = 0; i < 40 && cpu_wait; i++) @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_global = glob; cpu_addr = a;
    #1 hit = cpu_hit;
    @(posedge clk); @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input bit wr, input bit glob,
                       output logic [1:0] rep, output bit wt);
    bus_valid = 1; bus_write = wr; bus_global = glob; bus_addr = a;
    @(posedge clk); @(negedge clk);
    rep = snp_reply; wt = cpu_wait;
    bus_valid = 0; bus_write = 0; bus_global = 0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 40 && !m_req; i++) @(negedge clk);
  endtask

  task automatic serve_wb(input logic [ADDR_W-1:0] base, input bit req_after, input string req);
    wait_req();
    check(m_req, req, m_req, 1);
    bus_gnt = 1;
    for (int b = 0; b < BEATS; b++) begin
      @(posedge clk); @(negedge clk);
      check(m_valid && m_write && m_addr == base && m_beat == BW'(b), req,
            {m_valid, m_write, m_addr, 8'(m_beat)}, {2'b11, base, 8'(b)});
    end
    @(posedge clk); @(negedge clk);
    bus_gnt = 0;
    check(m_req == req_after && !m_valid, req, m_req, req_after);
  endtask

  task automatic serve_fill(input logic [ADDR_W-1:0] base, input bit glob, input logic [1:0] code);
    wait_req();
    bus_gnt = 1;
    @(posedge clk); @(negedge clk);
    check(m_valid && !m_write && m_addr == base && m_global == glob, "R8 read address phase",
          {m_valid, m_write, m_global, m_addr}, {3'b101 & {2'b11, glob}, base});
    @(posedge clk); @(negedge clk);
    bus_reply = code; bus_gnt = 0;
    @(posedge clk); @(negedge clk);
    bus_reply = 2'b00;
    if (code == 2'b11) begin
      int gap = 0;
      while (!m_req && gap < 20) begin
        gap++;
        @(posedge clk); @(negedge clk);
      end
      check(gap == GAP, "R8 retry gap length", gap, GAP);
    end else begin
      check(!m_req && !cpu_wait, "R9 fill completes", {m_req, cpu_wait}, 0);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] rep;
    bit wt, hit;
    logic [ADDR_W-1:0] A = 16'h0010, B = 16'h0090, C = 16'h0320, D = 16'h0450, E = 16'h0230;

    repeat (3) @(negedge clk);
    check(!cpu_wait && !m_req && !m_valid && snp_reply == 0, "reset state",
          {cpu_wait, m_req, m_valid, snp_reply}, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 read miss then hit
    cpu_access(A, 0, 0, hit);
    check(!hit, "R9 first access misses", hit, 0);
    serve_fill(A, 0, 2'b01);
    cpu_access(A + 4, 0, 0, hit);
    check(hit, "R9 installed line hits", hit, 1);

    // R12 write hit dirties; R1 non-global snoop ignored
    cpu_access(A, 1, 0, hit);
    check(hit, "R12 write hit", hit, 1);
    snoop(A, 0, 0, rep, wt);
    check(rep == 0 && !wt, "R1 non-global ignored", {rep, wt}, 0);
    @(negedge clk);
    check(!m_req, "R1 no bus request", m_req, 0);

    // R2 R7 abort, R4 writeback, R5 clean afterwards
    snoop(A + 8, 0, 1, rep, wt);
    check(rep == 2'b11, "R2 abort on modified", rep, 3);
    check(wt, "R7 wait during check", wt, 1);
    serve_wb(A, 0, "R4 writeback beats");
    snoop(A, 0, 1, rep, wt);
    check(rep == 0, "R5 clean after writeback", rep, 0);
    @(negedge clk);
    cpu_access(A, 0, 0, hit);
    check(hit, "R5 line still valid", hit, 1);

    // R3 clean hit and miss
    snoop(A, 0, 1, rep, wt);
    check(rep == 0 && wt, "R3 clean hit no abort", {rep, wt}, 1);
    snoop(C, 0, 1, rep, wt);
    check(rep == 0, "R3 miss no abort", rep, 0);
    @(negedge clk);
    cpu_access(A, 0, 0, hit);
    check(hit, "R3 clean line kept", hit, 1);

    // R6 write invalidates
    snoop(A, 1, 1, rep, wt);
    check(rep == 0, "R6 write snoop no abort", rep, 0);
    @(negedge clk);
    cpu_access(A, 0, 0, hit);
    check(!hit, "R6 line invalidated", hit, 0);
    serve_fill(A, 0, 2'b01);

    // R10 abort everything while writeback pending
    cpu_access(A, 1, 0, hit);
    snoop(A, 0, 1, rep, wt);
    check(rep == 2'b11, "R2 abort before R10", rep, 3);
    snoop(D, 0, 1, rep, wt);
    check(rep == 2'b11, "R10 pending writeback aborts miss", rep, 3);
    serve_wb(A, 0, "R4 writeback after R10");

    // R8 retry after abort
    cpu_access(E, 0, 1, hit);
    check(!hit, "R8 miss", hit, 0);
    serve_fill(E, 1, 2'b11);
    serve_fill(E, 1, 2'b01);
    cpu_access(E, 0, 0, hit);
    check(hit, "R9 hit after retry", hit, 1);

    // R11 dirty victim, R9 write-miss installs modified
    cpu_access(A, 1, 0, hit);
    cpu_access(B, 1, 0, hit);
    check(!hit, "R11 alias misses", hit, 0);
    serve_wb(A, 1, "R11 victim writeback");
    serve_fill(B, 0, 2'b01);
    snoop(B, 0, 1, rep, wt);
    check(rep == 2'b11, "R9 write miss installs modified", rep, 3);
    serve_wb(B, 0, "R4 writeback of B");
    snoop(A, 0, 1, rep, wt);
    check(rep == 0, "R11 victim evicted", rep, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule